// File: doc/BRIEF.md
# Byte-Wide Configuration Loader and Readback Master

This block writes a configuration image into a target programmable device over an 8-bit parallel configuration bus. It can also read configuration data back out of that device. It owns the device-side control pins: a program strobe, chip select, write direction, the configuration clock, and a data bus with its own output enable. It watches three status lines from the target: init, busy and done. Every wait on the target is bounded by a cycle counter, so a target that stalls ends the operation with a timeout code instead of hanging the block.

A host pulses `start`, with `mode_rd` choosing between load and readback and `xfer_len` giving the number of bytes. Load data enters on a valid/ready stream. A byte is taken on a cycle where both `in_valid` and `in_ready` are high. While `in_valid` is low the block waits and holds the configuration clock high. Readback bytes leave on a valid/ready stream. `out_valid` stays high with `out_data` unchanged until `out_ready` accepts the byte, and no further clock pulse is issued until then, so a slow consumer throttles the target directly.

Every operation ends in a one-cycle `status_valid` pulse that carries a 2-bit result code.

Top module: `cfgp_master`

## Requirements
- R1: A load begins with `cfg_prog` high for exactly PROG_CYC cycles, then low. `cfg_cs` is not asserted until both `tgt_init` and `tgt_busy` are seen low.
- R2: If init and busy do not both clear within TIMEOUT_CYC cycles after the program pulse, the load ends with status code 1, and chip select, write and output enable all stay low.
- R3: Chip select always rises while `cfg_clk` is high. During a load, write and chip select are asserted before the first byte. Each byte is presented on `cfg_dout` with `cfg_doe` high, and then exactly one clock pulse is issued, low then high. The target samples on the rising edge.
- R4: With `busy_chk_en` high, whenever `tgt_busy` is high after a byte's pulse, further pulses are issued with `cfg_dout` unchanged until busy falls.
- R5: If busy stays high past TIMEOUT_CYC cycles after the byte was taken, the load ends with status code 2 and all device controls released.
- R6: With `busy_chk_en` low, `tgt_busy` is ignored during the data phase, and exactly one pulse is issued per byte.
- R7: After the last byte, `cfg_cs` falls in an earlier cycle than `cfg_wr`. The block then checks `tgt_done` before each further pulse, and pulses until done is high, which gives status code 0. If done is not seen within TIMEOUT_CYC cycles, the status is code 3.
- R8: `in_ready` is high only while the block waits for a load byte. A low `in_valid` stalls the load with `cfg_clk` parked high.
- R9: Readback asserts chip select with write low and `cfg_doe` low. For each byte it issues one pulse and then captures `cfg_din` into `out_data`.
- R10: A readback byte stays on `out_valid`/`out_data` unchanged until `out_ready`. No clock pulse is issued while a byte is waiting.
- R11: Readback ends by dropping chip select and then issuing exactly one more clock pulse, followed by status code 0.
- R12: With `xfer_len` of zero, a load transfers no bytes and never raises `in_ready`, and still runs the done phase. A zero-length readback issues only the final pulse after chip select falls.
- R13: A `start` pulse while `active` is high has no effect. There is no second program pulse and no second status, and the running transfer completes unchanged. `status_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode_rd | input | 1 | 0 = load, 1 = readback, sampled with start |
| busy_chk_en | input | 1 | Stretch the clock on target busy during load |
| xfer_len | input | CNT_W | Number of bytes to move |
| in_valid | input | 1 | Load byte valid |
| in_data | input | DW | Load byte |
| in_ready | output | 1 | Block accepts a load byte |
| out_valid | output | 1 | Readback byte valid |
| out_data | output | DW | Readback byte |
| out_ready | input | 1 | Consumer accepts readback byte |
| active | output | 1 | Operation in progress |
| status_valid | output | 1 | One-cycle end-of-operation strobe |
| status_code | output | 2 | 0 ok, 1 init timeout, 2 busy timeout, 3 done timeout |
| cfg_prog | output | 1 | Program strobe to target (high = asserted) |
| cfg_cs | output | 1 | Chip select to target (high = asserted) |
| cfg_wr | output | 1 | Write direction to target (high = write) |
| cfg_clk | output | 1 | Configuration clock, idles high |
| cfg_dout | output | DW | Configuration data driven to target |
| cfg_doe | output | 1 | Output enable for cfg_dout |
| cfg_din | input | DW | Configuration data read from target |
| tgt_init | input | 1 | Target still initialising (high = not ready) |
| tgt_busy | input | 1 | Target busy |
| tgt_done | input | 1 | Target configuration complete |

## Verification
Loads are run against a behavioural target in several forms: a continuous byte stream, a stream with gaps in `in_valid`, a target that raises busy for a few pulses after one chosen byte, and a target whose busy is pinned high while checking is off. Comparing the captured bytes and counting pulses for each of these separates correct stretching from duplicated or dropped bytes. Each of the three waits is stalled on purpose to show that each timeout gives its own status code. Readback is driven with an always-ready consumer and with a consumer that accepts only every third cycle, which shows whether back-pressure holds both the byte and the clock. Zero-length transfers and a second start during a load cover the edges.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_PROG,
    S_INITW,
    S_SETUP,
    S_FETCH,
    S_WPULSE,
    S_WCHK,
    S_CSOFF,
    S_WROFF,
    S_DCHK,
    S_DPULSE,
    S_RSETUP,
    S_RPULSE,
    S_RHOLD,
    S_RCSOFF,
    S_RTAIL,
    S_FIN
  } cfgp_state_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_TO_INIT = 2'd1,
    ST_TO_BUSY = 2'd2,
    ST_TO_DONE = 2'd3
  } cfgp_status_e;

endpackage

// File: rtl/cfgp_clkpulse.sv
// Issues one configuration clock pulse per request: LOW_CYC cycles low,
// then HIGH_CYC cycles high, then a one-cycle completion strobe.
module cfgp_clkpulse #(
  parameter int LOW_CYC  = 2,
  parameter int HIGH_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic cclk,
  output logic done
);
  localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC + 1) : 1;

  logic          run_q;
  logic          low_q;
  logic [CW-1:0] cnt_q;
  logic          cclk_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      low_q  <= 1'b0;
      cnt_q  <= '0;
      cclk_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go && !run_q) begin
        run_q  <= 1'b1;
        low_q  <= 1'b1;
        cclk_q <= 1'b0;
        cnt_q  <= CW'(LOW_CYC - 1);
      end else if (run_q) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (low_q) begin
          low_q  <= 1'b0;
          cclk_q <= 1'b1;
          cnt_q  <= CW'(HIGH_CYC - 1);
        end else begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign cclk = cclk_q;
  assign done = done_q;

  // R3: a pulse only completes once the clock is back high
  a_r3_done_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cclk);
  // R3: a new pulse is never requested while one is still running
  a_r3_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !run_q);

endmodule

// File: rtl/cfgp_timer.sv
// Counts cycles while run is high, clears while low, saturates at LIMIT.
module cfgp_timer #(
  parameter int LIMIT = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (!run)                cnt_q <= '0;
    else if (cnt_q != TW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == TW'(LIMIT));

  // R2: once the window has run out it stays out until the wait ends
  a_r2_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (run && expired) |=> expired);

endmodule

// File: rtl/cfgp_master.sv
module cfgp_master
  import cfgp_pkg::*;
#(
  parameter int DW          = 8,
  parameter int CNT_W       = 16,
  parameter int PROG_CYC    = 4,
  parameter int LOW_CYC     = 2,
  parameter int HIGH_CYC    = 2,
  parameter int TIMEOUT_CYC = 2500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_rd,
  input  logic             busy_chk_en,
  input  logic [CNT_W-1:0] xfer_len,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  input  logic             out_ready,
  output logic             active,
  output logic             status_valid,
  output logic [1:0]       status_code,
  output logic             cfg_prog,
  output logic             cfg_cs,
  output logic             cfg_wr,
  output logic             cfg_clk,
  output logic [DW-1:0]    cfg_dout,
  output logic             cfg_doe,
  input  logic [DW-1:0]    cfg_din,
  input  logic             tgt_init,
  input  logic             tgt_busy,
  input  logic             tgt_done
);
  localparam int PW = (PROG_CYC > 1) ? $clog2(PROG_CYC + 1) : 1;

  cfgp_state_e  st_q, st_d;
  cfgp_status_e fin_code, code_q;
  logic [PW-1:0]    prog_cnt_q;
  logic [CNT_W-1:0] left_q;
  logic             bchk_q;
  logic [DW-1:0]    dout_q;
  logic [DW-1:0]    rbuf_q;
  logic             rvalid_q;
  logic             pg_go, pg_done, pg_clk;
  logic             tmr_run, tmr_exp;

  // ---------------- sequencing ----------------
  always_comb begin
    st_d     = st_q;
    fin_code = ST_OK;
    unique case (st_q)
      S_IDLE:   if (start) st_d = mode_rd ? S_RSETUP : S_PROG;
      S_PROG:   if (prog_cnt_q == PW'(PROG_CYC - 1)) st_d = S_INITW;
      S_INITW: begin
        if (!tgt_init && !tgt_busy) st_d = S_SETUP;
        else if (tmr_exp) begin
          st_d     = S_FIN;
          fin_code = ST_TO_INIT;
        end
      end
      S_SETUP:  st_d = (left_q == '0) ? S_CSOFF : S_FETCH;
      S_FETCH:  if (in_valid) st_d = S_WPULSE;
      S_WPULSE: if (pg_done) st_d = S_WCHK;
      S_WCHK: begin
        if (bchk_q && tgt_busy) begin
          if (tmr_exp) begin
            st_d     = S_FIN;
            fin_code = ST_TO_BUSY;
          end else begin
            st_d = S_WPULSE;
          end
        end else begin
          st_d = (left_q == '0) ? S_CSOFF : S_FETCH;
        end
      end
      S_CSOFF:  st_d = S_WROFF;
      S_WROFF:  st_d = S_DCHK;
      S_DCHK: begin
        if (tgt_done) st_d = S_FIN;
        else if (tmr_exp) begin
          st_d     = S_FIN;
          fin_code = ST_TO_DONE;
        end else begin
          st_d = S_DPULSE;
        end
      end
      S_DPULSE: if (pg_done) st_d = S_DCHK;
      S_RSETUP: st_d = (left_q == '0) ? S_RCSOFF : S_RPULSE;
      S_RPULSE: if (pg_done) st_d = S_RHOLD;
      S_RHOLD:  if (out_ready) st_d = (left_q == CNT_W'(1)) ? S_RCSOFF : S_RPULSE;
      S_RCSOFF: st_d = S_RTAIL;
      S_RTAIL:  if (pg_done) st_d = S_FIN;
      S_FIN:    st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      prog_cnt_q <= '0;
      left_q     <= '0;
      bchk_q     <= 1'b0;
      dout_q     <= '0;
      rbuf_q     <= '0;
      rvalid_q   <= 1'b0;
      code_q     <= ST_OK;
    end else begin
      st_q       <= st_d;
      prog_cnt_q <= (st_q == S_PROG) ? prog_cnt_q + 1'b1 : '0;
      if (st_q == S_IDLE && start) begin
        left_q <= xfer_len;
        bchk_q <= busy_chk_en;
      end
      if (st_q == S_FETCH && in_valid) begin
        dout_q <= in_data;
        left_q <= left_q - 1'b1;
      end
      if (st_q == S_RPULSE && pg_done) begin
        rbuf_q   <= cfg_din;
        rvalid_q <= 1'b1;
      end
      if (st_q == S_RHOLD && out_ready) begin
        rvalid_q <= 1'b0;
        left_q   <= left_q - 1'b1;
      end
      if (st_d == S_FIN && st_q != S_FIN) code_q <= fin_code;
    end
  end

  // ---------------- clock pulses and wait window ----------------
  assign pg_go   = (st_d != st_q) &&
                   (st_d inside {S_WPULSE, S_DPULSE, S_RPULSE, S_RTAIL});
  assign tmr_run = st_q inside {S_INITW, S_WPULSE, S_WCHK, S_DPULSE, S_DCHK};

  cfgp_clkpulse #(
    .LOW_CYC (LOW_CYC),
    .HIGH_CYC(HIGH_CYC)
  ) u_pulse (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (pg_go),
    .cclk (pg_clk),
    .done (pg_done)
  );

  cfgp_timer #(
    .LIMIT(TIMEOUT_CYC)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (tmr_run),
    .expired(tmr_exp)
  );

  // ---------------- outputs ----------------
  assign cfg_prog     = (st_q == S_PROG);
  assign cfg_cs       = st_q inside {S_SETUP, S_FETCH, S_WPULSE, S_WCHK,
                                     S_RSETUP, S_RPULSE, S_RHOLD};
  assign cfg_wr       = st_q inside {S_SETUP, S_FETCH, S_WPULSE, S_WCHK, S_CSOFF};
  assign cfg_doe      = cfg_wr;
  assign cfg_dout     = dout_q;
  assign cfg_clk      = pg_clk;
  assign in_ready     = (st_q == S_FETCH);
  assign out_valid    = rvalid_q;
  assign out_data     = rbuf_q;
  assign active       = (st_q != S_IDLE);
  assign status_valid = (st_q == S_FIN);
  assign status_code  = code_q;

  // ---------------- assertions ----------------
  // R3: chip select only rises with the clock parked high
  a_r3_cs_rise_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_cs) |-> cfg_clk);
  // R4: a stretch pulse keeps the byte on the bus
  a_r4_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WPULSE && $past(st_q) == S_WCHK) |-> $stable(cfg_dout));
  // R7: on a normal finish chip select is already low when write drops
  a_r7_cs_before_wr: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cfg_wr) && !status_valid) |-> $past(!cfg_cs));
  // R10: a waiting readback byte is held and no pulse is in flight
  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r10_no_clk_while_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cfg_clk);
  // R13: a start during a running operation never programs again
  a_r13_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && active) |=> !$rose(cfg_prog));
  a_r13_status_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |=> !status_valid);

endmodule

// File: tb/tb_cfgp_master.sv
`timescale 1ns/1ps
module tb_cfgp_master;
  localparam int DW = 8;
  localparam int CNT_W = 16;
  localparam int PROG_CYC = 3;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode_rd = 1'b0, busy_chk_en = 1'b0;
  logic [CNT_W-1:0] xfer_len = '0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_ready, active, status_valid;
  logic [DW-1:0] out_data;
  logic [1:0] status_code;
  logic cfg_prog, cfg_cs, cfg_wr, cfg_clk, cfg_doe;
  logic [DW-1:0] cfg_dout;
  logic [DW-1:0] cfg_din = 8'hFF;
  logic tgt_init = 1'b0, tgt_busy = 1'b0, tgt_done = 1'b0;

  always #2 clk = ~clk;

  cfgp_master #(.DW(DW), .CNT_W(CNT_W), .PROG_CYC(PROG_CYC), .LOW_CYC(2),
                .HIGH_CYC(2), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_rd(mode_rd),
    .busy_chk_en(busy_chk_en), .xfer_len(xfer_len), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .active(active),
    .status_valid(status_valid), .status_code(status_code),
    .cfg_prog(cfg_prog), .cfg_cs(cfg_cs), .cfg_wr(cfg_wr), .cfg_clk(cfg_clk),
    .cfg_dout(cfg_dout), .cfg_doe(cfg_doe), .cfg_din(cfg_din),
    .tgt_init(tgt_init), .tgt_busy(tgt_busy), .tgt_done(tgt_done));

  int checks = 0, fails = 0, cyc = 0;
  bit wd_hit = 0;

  // target model settings and observations
  int init_delay, init_cnt, stall_at, stall_len, busy_left, done_after, done_left;
  bit init_counting, force_busy;
  int or_mode;
  logic [7:0] cap [0:63];
  logic [7:0] rbcap [0:63];
  logic [7:0] held;
  int ncap, nrb, stall_edges, held_bad, load_edges, rb_edges, post_edges;
  int prog_rises, prog_cur, prog_w, status_cnt, last_code, cs_rises;
  int park_bad, csclk_bad, csinit_bad, doe_bad, hold_bad, ir_seen, rb_idx;
  int cs_fall_cyc, wr_fall_cyc;
  logic p_clk = 1, p_cs = 0, p_wr = 0, p_prog = 0, p_ov = 0, p_or = 0;
  logic [7:0] p_od = 0;

  function automatic logic [7:0] pat_in(int i);
    return 8'(i * 53 + 17) ^ 8'hC3;
  endfunction
  function automatic logic [7:0] pat_rb(int i);
    return 8'(i * 29) ^ 8'h5A;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cfg_cs && !p_cs) begin
        cs_rises++;
        if (!cfg_clk) csclk_bad++;
        if (tgt_init) csinit_bad++;
        if (force_busy) tgt_busy = 1'b1;
      end
      if (!cfg_cs && p_cs) cs_fall_cyc = cyc;
      if (!cfg_wr && p_wr) wr_fall_cyc = cyc;
      if (cfg_doe && !cfg_wr) doe_bad++;
      if (cfg_doe && !active) doe_bad++;
      if (in_ready) ir_seen++;
      if (in_ready && !in_valid && !cfg_clk) park_bad++;
      if (status_valid) begin status_cnt++; last_code = status_code; end
      // program strobe and init model
      if (cfg_prog && !p_prog) begin
        prog_rises++; prog_cur = 0; tgt_init = 1'b1;
        done_left = done_after; tgt_done = (done_after == 0);
      end
      if (cfg_prog) prog_cur++;
      if (!cfg_prog && p_prog) begin prog_w = prog_cur; init_cnt = init_delay; init_counting = 1; end
      if (init_counting) begin
        if (init_cnt == 0) begin tgt_init = 1'b0; init_counting = 0; end
        else init_cnt--;
      end
      // rising configuration clock
      if (cfg_clk && !p_clk) begin
        if (cfg_cs && cfg_wr) begin
          load_edges++;
          if (force_busy || busy_left == 0) begin
            if (ncap < 64) cap[ncap] = cfg_dout;
            ncap++;
            if (!force_busy && stall_len > 0 && ncap - 1 == stall_at) begin
              tgt_busy = 1'b1; busy_left = stall_len; held = cfg_dout;
            end
          end else begin
            stall_edges++;
            if (cfg_dout !== held) held_bad++;
            busy_left--;
            if (busy_left == 0) tgt_busy = 1'b0;
          end
        end else if (cfg_cs) begin
          rb_edges++; cfg_din = pat_rb(rb_idx); rb_idx++;
        end else begin
          post_edges++;
          if (done_left > 0) begin
            done_left--;
            if (done_left == 0) tgt_done = 1'b1;
          end
        end
      end
      // readback consumer
      if (p_ov && !p_or && (!out_valid || out_data !== p_od)) hold_bad++;
      out_ready = (or_mode == 0) ? 1'b1 : (cyc % 3 == 0);
      if (out_valid && out_ready) begin
        if (nrb < 64) rbcap[nrb] = out_data;
        nrb++;
      end
    end
    p_clk = cfg_clk; p_cs = cfg_cs; p_wr = cfg_wr; p_prog = cfg_prog;
    p_ov = out_valid; p_or = out_ready; p_od = out_data;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1; fails++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    tgt_init = 0; tgt_busy = 0; tgt_done = 0; init_counting = 0;
    busy_left = 0; force_busy = 0; stall_len = 0; stall_at = -1;
    init_delay = 5; done_after = 2; done_left = 0; or_mode = 0;
    ncap = 0; nrb = 0; stall_edges = 0; held_bad = 0; load_edges = 0;
    rb_edges = 0; post_edges = 0; prog_rises = 0; prog_w = 0; status_cnt = 0;
    last_code = -1; cs_rises = 0; park_bad = 0; csclk_bad = 0; csinit_bad = 0;
    doe_bad = 0; hold_bad = 0; ir_seen = 0; rb_idx = 0;
    cs_fall_cyc = 0; wr_fall_cyc = 0;
  endtask

  task automatic run_op(bit rd, int n, int gap, bit bce, bit extra);
    bit fin = 0;
    @(negedge clk);
    xfer_len = CNT_W'(n); mode_rd = rd; busy_chk_en = bce; start = 1;
    @(negedge clk);
    start = 0; mode_rd = 0;
    fork
      begin
        if (!rd) begin
          for (int i = 0; i < n && !fin; i++) begin
            if (gap > 0) begin in_valid = 0; repeat (gap) @(negedge clk); end
            in_valid = 1; in_data = pat_in(i);
            while (!in_ready && !fin) @(negedge clk);
            @(negedge clk);
          end
          in_valid = 0;
        end
      end
      begin
        int t = 0;
        while (!status_valid && t < 20000) begin @(negedge clk); t++; end
        fin = 1;
        @(negedge clk);
      end
      begin
        if (extra) begin
          repeat (25) @(negedge clk);
          start = 1; mode_rd = 1;
          @(negedge clk);
          start = 0; mode_rd = 0;
        end
      end
    join
    in_valid = 0;
  endtask

  task automatic check_load_data(string req, int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (cap[i] !== pat_in(i)) bad++;
    chk(req, "captured byte count", ncap, n);
    chk(req, "captured byte mismatches", bad, 0);
  endtask

  task automatic check_rb_data(string req, int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (rbcap[i] !== pat_rb(i)) bad++;
    chk(req, "readback byte count", nrb, n);
    chk(req, "readback byte mismatches", bad, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R13", "reset active", active, 0);
    chk("R3", "reset cs/wr/doe/prog", {cfg_cs, cfg_wr, cfg_doe, cfg_prog}, 0);
    chk("R3", "reset clk parked high", cfg_clk, 1);
    chk("R8", "reset in_ready", in_ready, 0);
    chk("R10", "reset out_valid", out_valid, 0);
    rst_n = 1;
  endtask

  task automatic t_basic_load();
    clear_model();
    run_op(0, 5, 0, 1, 0);
    chk("R1", "program pulse width", prog_w, PROG_CYC);
    chk("R1", "cs rose during init", csinit_bad, 0);
    chk("R3", "cs rose with clock low", csclk_bad, 0);
    chk("R3", "pulses with cs and wr", load_edges, 5);
    check_load_data("R3", 5);
    chk("R7", "cs fell before wr", (cs_fall_cyc < wr_fall_cyc) ? 1 : 0, 1);
    chk("R7", "pulses until done", post_edges, 2);
    chk("R7", "status code", last_code, 0);
    chk("R13", "doe outside write", doe_bad, 0);
  endtask

  task automatic t_gappy_load();
    clear_model();
    run_op(0, 4, 4, 1, 0);
    check_load_data("R8", 4);
    chk("R8", "clock not parked while starved", park_bad, 0);
    chk("R8", "status code", last_code, 0);
  endtask

  task automatic t_busy_stretch();
    clear_model();
    stall_at = 2; stall_len = 3;
    run_op(0, 6, 0, 1, 0);
    check_load_data("R4", 6);
    chk("R4", "stretch pulses", stall_edges, 3);
    chk("R4", "byte changed in stretch", held_bad, 0);
    chk("R4", "status code", last_code, 0);
  endtask

  task automatic t_busy_ignored();
    clear_model();
    force_busy = 1;
    run_op(0, 4, 0, 0, 0);
    chk("R6", "pulses with busy ignored", load_edges, 4);
    check_load_data("R6", 4);
    chk("R6", "status code", last_code, 0);
  endtask

  task automatic t_busy_timeout();
    clear_model();
    stall_at = 1; stall_len = 1000;
    run_op(0, 4, 0, 1, 0);
    chk("R5", "status code", last_code, 2);
    chk("R5", "controls after abort", {cfg_cs, cfg_wr, cfg_doe, cfg_prog}, 0);
    chk("R5", "active after abort", active, 0);
  endtask

  task automatic t_init_timeout();
    clear_model();
    init_delay = 1000;
    run_op(0, 3, 0, 1, 0);
    chk("R2", "status code", last_code, 1);
    chk("R2", "cs never asserted", cs_rises, 0);
    chk("R2", "doe never asserted", doe_bad + load_edges, 0);
  endtask

  task automatic t_done_timeout();
    clear_model();
    done_after = 1000;
    run_op(0, 2, 0, 1, 0);
    check_load_data("R7", 2);
    chk("R7", "status code on missing done", last_code, 3);
  endtask

  task automatic t_zero_load();
    clear_model();
    run_op(0, 0, 0, 1, 0);
    chk("R12", "in_ready cycles", ir_seen, 0);
    chk("R12", "data pulses", load_edges, 0);
    chk("R12", "done-phase pulses", post_edges, 2);
    chk("R12", "status code", last_code, 0);
  endtask

  task automatic t_readback(int ormode, string req);
    clear_model();
    or_mode = ormode;
    run_op(1, 5, 0, 0, 0);
    check_rb_data(req, 5);
    chk("R9", "pulses with cs in readback", rb_edges, 5);
    chk("R9", "write pulses in readback", load_edges, 0);
    chk("R9", "doe in readback", doe_bad, 0);
    chk("R10", "held byte changed", hold_bad, 0);
    chk("R11", "tail pulses", post_edges, 1);
    chk("R11", "status code", last_code, 0);
  endtask

  task automatic t_zero_readback();
    clear_model();
    run_op(1, 0, 0, 0, 0);
    chk("R12", "readback pulses with cs", rb_edges, 0);
    chk("R12", "readback tail pulses", post_edges, 1);
    chk("R12", "readback bytes", nrb, 0);
  endtask

  task automatic t_start_ignored();
    clear_model();
    run_op(0, 5, 2, 1, 1);
    chk("R13", "program pulses", prog_rises, 1);
    chk("R13", "status strobes", status_cnt, 1);
    chk("R13", "readback pulses", rb_edges, 0);
    check_load_data("R13", 5);
  endtask

  initial begin
    out_ready = 1'b1;
    clear_model();
    t_reset();
    t_basic_load();
    t_gappy_load();
    t_busy_stretch();
    t_busy_ignored();
    t_busy_timeout();
    t_init_timeout();
    t_done_timeout();
    t_zero_load();
    t_readback(0, "R9");
    t_readback(1, "R10");
    t_zero_readback();
    t_start_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule